// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Translator

This block is a 4 KB register frame on a simple 32-bit little-endian register bus. It turns message-signalled interrupt writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A requester writes a global interrupt ID to the doorbell register. The frame rebases that ID against its configured window and pulses the matching output line. IDs outside the window are dropped without any effect.

Software discovers the window through a read-only type register, which reports the window's first global ID and its line count. A second read-only register reports a fixed product code. The frame has two elaboration-time parameters: the first line's index relative to the shared-interrupt base (`BASE_IDX`, default 0) and the number of lines (`NUM_LINES`, default 64). An illegal combination fails elaboration. The line count may not exceed 128, and `BASE_IDX + 32 + NUM_LINES` may not exceed 1020. The bus has no wait states. Read data is registered.

Top module: `msi_doorbell_xlate`

## Requirements
- R1: While `rst_n` is low, `bus_rdata` and `irq_pulse` are all zero.
- R2: A 4-byte read at offset 0x008 returns `((BASE_IDX+32) << 16) | NUM_LINES` on `bus_rdata` in the cycle after the read strobe (0x0020_0040 with the defaults).
- R3: A 4-byte read at offset 0xFCC returns 0x0510_0000, which is the code 0x51 in bits [27:20] with all other bits zero.
- R4: A 4-byte read at any offset in 0xFD0..0xFFC, or at any other offset except 0x008 and 0xFCC (the doorbell included), returns zero. `bus_rdata` is zero in every cycle that follows a cycle without a read strobe.
- R5: `bus_size` holds the access width in bytes (1, 2 or 4; other codes are invalid). A read with any size other than 4 returns zero.
- R6: A write at offset 0x040 takes `bus_wdata[9:0]` as a global ID and ignores bits [31:10]. If the ID lies in `BASE_IDX+32 .. BASE_IDX+31+NUM_LINES`, then line `ID-(BASE_IDX+32)` of `irq_pulse` is high in the cycle after the write.
- R7: Each accepted doorbell write raises its line for exactly one cycle. At most one line is high in any cycle. Writes in consecutive cycles give one pulse cycle each, in the same order as the writes, with no merging and no queuing.
- R8: A doorbell ID below `BASE_IDX+32` or at or above `BASE_IDX+32+NUM_LINES` raises no line.
- R9: A doorbell write with a size other than 2 or 4 raises no line.
- R10: A write to any offset other than 0x040 raises no line and leaves the read values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_size | input | 3 | Access width in bytes (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one bit per line |

## Verification
Every result of this block arrives exactly one clock edge after the strobe that caused it. Read data appears in the cycle after the read strobe. A doorbell pulse appears in the cycle after the write, and the line must be low again one cycle later. The bench drives each access on a falling edge and drops the strobes on the next falling edge. It checks `bus_rdata` and `irq_pulse` there and then checks `irq_pulse` once more a cycle later, so that both the arrival cycle and the one-cycle width are pinned. The back-to-back cases sample each following cycle in turn.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 10;

  localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;

  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  localparam logic [7:0] PRODUCT_CODE = 8'h51;
  localparam int unsigned PRODUCT_LSB = 20;

  localparam int unsigned SHARED_OFS = 32;
  localparam int unsigned MAX_LINES  = 128;
  localparam int unsigned MAX_ID     = 1020;
endpackage

// File: rtl/msi_read_mux.sv
module msi_read_mux
  import msi_xlate_pkg::*;
#(
  parameter int unsigned BASE_IDX  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata_d
);
  localparam int unsigned WIN_LO = BASE_IDX + SHARED_OFS;
  localparam logic [DATA_W-1:0] TYPE_VAL =
    (DATA_W'(WIN_LO) << 16) | DATA_W'(NUM_LINES);
  localparam logic [DATA_W-1:0] IDENT_VAL =
    DATA_W'(PRODUCT_CODE) << PRODUCT_LSB;

  logic word_rd;
  assign word_rd = rd && (size == SZ_WORD);

  always_comb begin
    rdata_d = '0;
    if (word_rd) begin
      unique case (addr)
        OFS_TYPE:  rdata_d = TYPE_VAL;
        OFS_IDENT: rdata_d = IDENT_VAL;
        default:   rdata_d = '0;
      endcase
    end
  end
endmodule

// File: rtl/msi_doorbell_decode.sv
module msi_doorbell_decode
  import msi_xlate_pkg::*;
#(
  parameter int unsigned BASE_IDX  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [2:0]           size,
  input  logic                 wr,
  input  logic [ID_W-1:0]      id,
  output logic [NUM_LINES-1:0] fire
);
  localparam int unsigned WIN_LO = BASE_IDX + SHARED_OFS;

  logic size_ok;
  logic bell_hit;

  assign size_ok  = (size == SZ_HALF) || (size == SZ_WORD);
  assign bell_hit = wr && size_ok && (addr == OFS_DOORBELL);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign fire[i] = bell_hit && (id == ID_W'(WIN_LO + i));
  end
endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] fire,
  output logic [NUM_LINES-1:0] pulse
);
  logic [NUM_LINES-1:0] pulse_d;
  logic [NUM_LINES-1:0] pulse_q;
  logic                 pulse_en;

  assign pulse_en = (|fire) || (|pulse_q);

  always_comb begin
    pulse_d = pulse_q;
    if (pulse_en) pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/msi_doorbell_xlate.sv
module msi_doorbell_xlate
  import msi_xlate_pkg::*;
#(
  parameter int unsigned BASE_IDX  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic [2:0]           bus_size,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);
  if (NUM_LINES < 1 || NUM_LINES > MAX_LINES ||
      BASE_IDX + SHARED_OFS + NUM_LINES > MAX_ID) begin : g_bad_cfg
    $error("msi_doorbell_xlate: line window out of legal range");
  end

  logic [DATA_W-1:0]    rdata_d;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rdata_en;
  logic [NUM_LINES-1:0] fire;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:ID_W];

  msi_read_mux #(
    .BASE_IDX (BASE_IDX),
    .NUM_LINES(NUM_LINES)
  ) u_rd_mux (
    .addr   (bus_addr),
    .size   (bus_size),
    .rd     (bus_rd),
    .rdata_d(rdata_d)
  );

  msi_doorbell_decode #(
    .BASE_IDX (BASE_IDX),
    .NUM_LINES(NUM_LINES)
  ) u_decode (
    .addr(bus_addr),
    .size(bus_size),
    .wr  (bus_wr),
    .id  (bus_wdata[ID_W-1:0]),
    .fire(fire)
  );

  msi_pulse_bank #(
    .NUM_LINES(NUM_LINES)
  ) u_pulses (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .pulse(irq_pulse)
  );

  assign rdata_en = bus_rd || (|rdata_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/msi_doorbell_xlate_chk.sv
module msi_doorbell_xlate_chk #(
  parameter int unsigned BASE_IDX  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [11:0]          bus_addr,
  input logic [2:0]           bus_size,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_pulse
);
  localparam int unsigned WIN_LO = BASE_IDX + 32;
  localparam int unsigned WIN_HI = WIN_LO + NUM_LINES;
  localparam int unsigned LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [31:0] TYPE_EXP = (32'(WIN_LO) << 16) | 32'(NUM_LINES);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic [10:0] id_ext;
  logic [10:0] idx_now;
  logic        bell;
  logic        in_win;
  assign id_ext  = {1'b0, bus_wdata[9:0]};
  assign idx_now = id_ext - 11'(WIN_LO);
  assign bell    = bus_wr && bus_addr == 12'h040 &&
                   (bus_size == 3'd2 || bus_size == 3'd4);
  assign in_win  = id_ext >= 11'(WIN_LO) && id_ext < 11'(WIN_HI);

  p_type_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 3'd4 && bus_addr == 12'h008) |=> bus_rdata == TYPE_EXP);

  p_ident_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 3'd4 && bus_addr == 12'hFCC) |=> bus_rdata == 32'h0510_0000);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0);

  p_narrow_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size != 3'd4) |=> bus_rdata == 32'h0);

  p_line_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && in_win) |=> irq_pulse[$past(idx_now[LW-1:0])]);

  p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (irq_pulse != '0) |-> $past(bus_wr));

  p_out_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && !in_win) |=> irq_pulse == '0);

  p_bad_wsize_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != 3'd2 && bus_size != 3'd4) |=> irq_pulse == '0);

  p_other_ofs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 12'h040) |=> irq_pulse == '0);
endmodule

bind msi_doorbell_xlate msi_doorbell_xlate_chk #(
  .BASE_IDX (BASE_IDX),
  .NUM_LINES(NUM_LINES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_size (bus_size),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_pulse(irq_pulse)
);

// File: tb/msi_doorbell_xlate_tb_top.sv
module msi_doorbell_xlate_tb_top;
  localparam int unsigned NL = 64;

  typedef struct packed {
    logic        is_wr;
    logic [11:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_hit;
    logic [6:0]  exp_line;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h008, 3'd4, 32'h0,         32'h0020_0040, 1'b0, 7'd0,  8'd2},  // R2
    '{1'b0, 12'h008, 3'd2, 32'h0,         32'h0,         1'b0, 7'd0,  8'd5},  // R5
    '{1'b0, 12'hFCC, 3'd1, 32'h0,         32'h0,         1'b0, 7'd0,  8'd5},  // R5
    '{1'b0, 12'hFCC, 3'd4, 32'h0,         32'h0510_0000, 1'b0, 7'd0,  8'd3},  // R3
    '{1'b0, 12'hFD0, 3'd4, 32'h0,         32'h0,         1'b0, 7'd0,  8'd4},  // R4
    '{1'b0, 12'hFFC, 3'd4, 32'h0,         32'h0,         1'b0, 7'd0,  8'd4},  // R4
    '{1'b0, 12'h040, 3'd4, 32'h0,         32'h0,         1'b0, 7'd0,  8'd4},  // R4
    '{1'b0, 12'h100, 3'd4, 32'h0,         32'h0,         1'b0, 7'd0,  8'd4},  // R4
    '{1'b1, 12'h040, 3'd4, 32'd32,        32'h0,         1'b1, 7'd0,  8'd6},  // R6 lowest
    '{1'b1, 12'h040, 3'd2, 32'd95,        32'h0,         1'b1, 7'd63, 8'd6},  // R6 highest
    '{1'b1, 12'h040, 3'd4, 32'hFFFF_FC32, 32'h0,         1'b1, 7'd18, 8'd6},  // R6 upper bits ignored
    '{1'b1, 12'h040, 3'd4, 32'd96,        32'h0,         1'b0, 7'd0,  8'd8},  // R8 above
    '{1'b1, 12'h040, 3'd4, 32'd31,        32'h0,         1'b0, 7'd0,  8'd8},  // R8 below
    '{1'b1, 12'h040, 3'd1, 32'd40,        32'h0,         1'b0, 7'd0,  8'd9},  // R9
    '{1'b1, 12'h040, 3'd3, 32'd40,        32'h0,         1'b0, 7'd0,  8'd9},  // R9
    '{1'b1, 12'h008, 3'd4, 32'd40,        32'h0,         1'b0, 7'd0,  8'd10}, // R10
    '{1'b0, 12'h008, 3'd4, 32'h0,         32'h0020_0040, 1'b0, 7'd0,  8'd10}  // R10 type unchanged
  };

  logic          clk;
  logic          rst_n;
  logic [11:0]   bus_addr;
  logic [2:0]    bus_size;
  logic          bus_rd;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_pulse;

  int checks;
  int failures;

  msi_doorbell_xlate #(.BASE_IDX(0), .NUM_LINES(NL)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = 3'd4; bus_wdata = '0;
  endtask

  task automatic bell(input logic [9:0] id);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = 12'h040; bus_size = 3'd4;
    bus_wdata = {22'h0, id};
  endtask

  function automatic logic [NL-1:0] line_bit(input int n);
    return NL'(1) << n;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    idle_bus();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bus_rdata == 32'h0, "R1 rdata in reset", 64'(bus_rdata), 64'h0);
    check(irq_pulse == '0, "R1 irq in reset", irq_pulse, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata == 32'h0, "R4 rdata idle", 64'(bus_rdata), 64'h0);

    for (int v = 0; v < NV; v++) begin
      bus_rd    = !VECS[v].is_wr;
      bus_wr    = VECS[v].is_wr;
      bus_addr  = VECS[v].addr;
      bus_size  = VECS[v].size;
      bus_wdata = VECS[v].data;
      @(negedge clk);
      idle_bus();
      begin
        logic [NL-1:0] ep;
        ep = VECS[v].exp_hit ? line_bit(int'(VECS[v].exp_line)) : '0;
        check(bus_rdata == VECS[v].exp_rd, $sformatf("R%0d vec %0d rdata", VECS[v].req, v),
              64'(bus_rdata), 64'(VECS[v].exp_rd));
        check(irq_pulse == ep, $sformatf("R%0d vec %0d irq", VECS[v].req, v),
              irq_pulse, ep);
      end
      @(negedge clk);
      // R7: pulse lasts one cycle
      check(irq_pulse == '0, $sformatf("R7 vec %0d pulse width", v), irq_pulse, 64'h0);
      check(bus_rdata == 32'h0, $sformatf("R4 vec %0d rdata after", v), 64'(bus_rdata), 64'h0);
    end

    // R7: back-to-back writes to one line
    bell(10'd37);
    @(negedge clk);
    bell(10'd37);
    check(irq_pulse == line_bit(5), "R7 b2b same first", irq_pulse, line_bit(5));
    @(negedge clk);
    idle_bus();
    check(irq_pulse == line_bit(5), "R7 b2b same second", irq_pulse, line_bit(5));
    @(negedge clk);
    check(irq_pulse == '0, "R7 b2b same end", irq_pulse, 64'h0);

    // R7: back-to-back writes to different lines keep order
    bell(10'd35);
    @(negedge clk);
    bell(10'd36);
    check(irq_pulse == line_bit(3), "R7 b2b diff first", irq_pulse, line_bit(3));
    @(negedge clk);
    bell(10'd100);
    check(irq_pulse == line_bit(4), "R7 b2b diff second", irq_pulse, line_bit(4));
    @(negedge clk);
    idle_bus();
    check(irq_pulse == '0, "R8 b2b out of window", irq_pulse, 64'h0);

    // R1: asynchronous reset clears a live pulse
    bell(10'd50);
    @(negedge clk);
    idle_bus();
    check(irq_pulse == line_bit(18), "R6 before reset", irq_pulse, line_bit(18));
    #2 rst_n = 1'b0;
    #1 check(irq_pulse == '0, "R1 async clear", irq_pulse, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule